// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers interrupt requests from eight sources and drives one interrupt line to the processor. Each request is captured on its rising edge. The block picks the lowest-numbered unmasked pending line and compares it with the work already in service. When the processor acknowledges, the block hands back an 8-bit vector that names the winner. The vector is formed from a 5-bit base field followed by the 3-bit line number.

Service can nest. An in-service flag is set for each acknowledged line and is cleared by an end-of-interrupt pulse. A new request interrupts the processor only if it outranks every line still in service.

A second controller can be linked in through line 2. In linked mode the secondary's interrupt output replaces line 2's request, and the secondary supplies the vector. This gives 15 usable lines. Line 2's own request pin is passed out so that it can be wired to the secondary's line 1, which is system line 9. The vector leaves the block through a valid/ready handshake. While `vec_valid` is high and `vec_ready` is low, the vector is held unchanged and any further acknowledge is ignored.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, no request is latched, nothing is in service, and `intr`, `vec_valid` and `casc_ack` are low.
- R2: A line is latched only on a 0-to-1 change of its request. It stays latched after the input drops. A level held high after acknowledge does not latch again.
- R3: A latched request whose `mask` bit is 1 does not raise `intr`. It stays latched and raises `intr` once unmasked.
- R4: Among unmasked latched lines, line 0 has the highest priority and line 7 the lowest. The vector is `{vec_base, line[2:0]}`.
- R5: `inta` high while `intr` is high is an acknowledge. At the next edge `vec_valid` rises with the winner's vector, that line's latch clears and its in-service flag sets. `intr` stays low while `vec_valid` is high.
- R6: While `vec_valid` is high and `vec_ready` is low, `vec_data` holds its value and `inta` is ignored. The vector is taken at an edge where both are high.
- R7: `intr` rises for a pending line only if that line's number is below the lowest-numbered in-service line. Equal or lower-priority lines wait.
- R8: An `eoi` pulse clears the in-service flag of the highest-priority line in service. After that, requests it held off may raise `intr`.
- R9: With `casc_en`=1, line 2 is fed by `casc_irq`. Acknowledging line 2 makes `casc_ack` high in that cycle, and the vector returned is `casc_vec` sampled at that edge.
- R10: `reroute_req` equals `req[2]` when `casc_en`=1 and is 0 otherwise. In linked mode, `req[2]` does not latch line 2.
- R11: If a rising edge arrives on a line in the very cycle that line is acknowledged, the new request stays latched. An acknowledge and an `eoi` in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Request lines, one per source |
| mask | input | 8 | 1 blocks the corresponding line |
| vec_base | input | 5 | Upper vector bits |
| casc_en | input | 1 | Linked mode: line 2 comes from the secondary |
| casc_irq | input | 1 | Interrupt output of the secondary |
| casc_vec | input | 8 | Vector supplied by the secondary |
| inta | input | 1 | Processor acknowledge |
| eoi | input | 1 | End-of-interrupt pulse |
| vec_ready | input | 1 | Consumer accepts the vector |
| intr | output | 1 | Interrupt to the processor |
| vec_valid | output | 1 | Vector available |
| vec_data | output | 8 | Vector |
| casc_ack | output | 1 | Acknowledge forwarded to the secondary |
| reroute_req | output | 1 | Line 2 request passed on to the secondary |

## Verification
Several actions can land on the same clock edge, and each collision is provoked on purpose. In one case, a line is acknowledged in the same cycle that a fresh rising edge appears on it. The check is that the line is latched again and, once its service ends, raises `intr` again. In another case, an acknowledge and an `eoi` arrive together. The check then raises a lower-priority request: `intr` may only rise if the old in-service flag really cleared while the new one was set. A behavioural model in the bench recomputes `intr`, the handshake and the vector every cycle, and targeted checks compare against hand-worked vectors.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_eff,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  irr
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise = req_eff & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= req_eff;
  end

  // a fresh edge wins over the clear that an acknowledge of the same line makes
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                irr[g] <= 1'b0;
      else if (rise[g])                          irr[g] <= 1'b1;
      else if (clr_en && (clr_idx == IW'(g)))    irr[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  isr,
  output logic          pend,
  output logic [IW-1:0] win_idx
);
  logic [N-1:0]  cand;
  logic          win_any;
  logic          svc_any;
  logic [IW-1:0] svc_idx;

  assign cand = irr & ~mask;

  // scanning downward leaves the lowest set index in the result
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    svc_any = 1'b0;
    svc_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        win_any = 1'b1;
        win_idx = IW'(i);
      end
      if (isr[i]) begin
        svc_any = 1'b1;
        svc_idx = IW'(i);
      end
    end
  end

  assign pend = win_any && (!svc_any || (win_idx < svc_idx));
endmodule

// File: rtl/irq_service.sv
module irq_service #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          eoi,
  output logic [N-1:0]  isr
);
  logic [N-1:0] top_bit;
  logic [N-1:0] set_vec;
  logic [N-1:0] isr_nxt;

  // isolate the lowest set bit, i.e. the highest-priority line in service
  assign top_bit = isr & (~isr + N'(1));
  assign set_vec = set_en ? (N'(1) << set_idx) : '0;
  assign isr_nxt = (isr & ~(eoi ? top_bit : '0)) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_nxt;
  end
endmodule

// File: rtl/irq_vec_out.sv
module irq_vec_out
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  vec_t load_data,
  input  logic ready,
  output logic valid,
  output vec_t data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_LINES   = 8,
  parameter int unsigned CASC_LINE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_LINES-1:0]    req,
  input  logic [N_LINES-1:0]    mask,
  input  logic [VEC_W-$clog2(N_LINES)-1:0] vec_base,
  input  logic                  casc_en,
  input  logic                  casc_irq,
  input  logic [VEC_W-1:0]      casc_vec,
  input  logic                  inta,
  input  logic                  eoi,
  input  logic                  vec_ready,
  output logic                  intr,
  output logic                  vec_valid,
  output logic [VEC_W-1:0]      vec_data,
  output logic                  casc_ack,
  output logic                  reroute_req
);
  localparam int unsigned IW = $clog2(N_LINES);

  logic [N_LINES-1:0] req_eff;
  logic [N_LINES-1:0] irr_q;
  logic [N_LINES-1:0] isr_q;
  logic               pend;
  logic [IW-1:0]      win_idx;
  logic               ack_go;
  vec_t               load_vec;

  always_comb begin
    req_eff = req;
    if (casc_en) req_eff[CASC_LINE] = casc_irq;
  end

  irq_req_latch #(.N(N_LINES), .IW(IW)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_eff(req_eff),
    .clr_en(ack_go), .clr_idx(win_idx), .irr(irr_q)
  );

  irq_prio_resolve #(.N(N_LINES), .IW(IW)) u_prio (
    .irr(irr_q), .mask(mask), .isr(isr_q), .pend(pend), .win_idx(win_idx)
  );

  irq_service #(.N(N_LINES), .IW(IW)) u_svc (
    .clk(clk), .rst_n(rst_n), .set_en(ack_go), .set_idx(win_idx),
    .eoi(eoi), .isr(isr_q)
  );

  assign intr        = pend && !vec_valid;
  assign ack_go      = inta && intr;
  assign casc_ack    = ack_go && casc_en && (win_idx == IW'(CASC_LINE));
  assign reroute_req = casc_en && req[CASC_LINE];
  assign load_vec    = casc_ack ? casc_vec : {vec_base, win_idx};

  irq_vec_out u_vout (
    .clk(clk), .rst_n(rst_n), .load(ack_go), .load_data(load_vec),
    .ready(vec_ready), .valid(vec_valid), .data(vec_data)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] mask,
  input logic [N-1:0] irr,
  input logic         casc_en,
  input logic [7:0]   casc_vec,
  input logic         inta,
  input logic         intr,
  input logic         vec_valid,
  input logic         vec_ready,
  input logic [7:0]   vec_data,
  input logic         casc_ack,
  input logic         reroute_req
);
  a_r3_intr_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> ((irr & ~mask) != '0));

  a_r5_ack_loads_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && intr) |=> vec_valid);

  a_r5_intr_quiet_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !intr);

  a_r6_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)));

  a_r9_casc_ack_context: assert property (@(posedge clk) disable iff (!rst_n)
    casc_ack |-> (casc_en && inta && intr));

  a_r9_casc_vector_used: assert property (@(posedge clk) disable iff (!rst_n)
    casc_ack |=> (vec_data == $past(casc_vec)));

  a_r10_no_reroute_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
    !casc_en |-> !reroute_req);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask(mask), .irr(irr_q), .casc_en(casc_en),
  .casc_vec(casc_vec), .inta(inta), .intr(intr), .vec_valid(vec_valid),
  .vec_ready(vec_ready), .vec_data(vec_data), .casc_ack(casc_ack),
  .reroute_req(reroute_req)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, casc_vec = '0;
  logic [4:0] vec_base = 5'h0A;
  logic casc_en = 0, casc_irq = 0, inta = 0, eoi = 0, vec_ready = 1;
  logic intr, vec_valid, casc_ack, reroute_req;
  logic [7:0] vec_data;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .mask(mask), .vec_base(vec_base),
    .casc_en(casc_en), .casc_irq(casc_irq), .casc_vec(casc_vec), .inta(inta),
    .eoi(eoi), .vec_ready(vec_ready), .intr(intr), .vec_valid(vec_valid),
    .vec_data(vec_data), .casc_ack(casc_ack), .reroute_req(reroute_req)
  );

  // behavioural reference
  logic [7:0] m_irr = '0, m_isr = '0, m_prev = '0, m_vec = '0;
  logic m_vv = 0;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic m_intr();
    int w, s;
    w = lowest(m_irr & ~mask);
    s = lowest(m_isr);
    return (w < 8) && (w < s) && !m_vv;
  endfunction

  function automatic logic m_cack();
    return inta && m_intr() && casc_en && (lowest(m_irr & ~mask) == 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_prev = '0; m_vv = 0; m_vec = '0;
    end else begin
      logic [7:0] eff;
      logic go, ca;
      int w, s;
      eff = req;
      if (casc_en) eff[2] = casc_irq;
      w  = lowest(m_irr & ~mask);
      s  = lowest(m_isr);
      go = inta && m_intr();
      ca = m_cack();
      if (eoi && s < 8) m_isr[s] = 1'b0;
      if (go) begin
        m_isr[w] = 1'b1;
        m_irr[w] = 1'b0;
      end
      m_irr  = m_irr | (eff & ~m_prev);
      m_prev = eff;
      if (go) begin
        m_vv  = 1'b1;
        m_vec = ca ? casc_vec : {vec_base, 3'(w)};
      end else if (vec_ready) m_vv = 1'b0;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(8'(intr), 8'(m_intr()), "R7 model intr");
    chk(8'(vec_valid), 8'(m_vv), "R5 model vec_valid");
    chk(8'(casc_ack), 8'(m_cack()), "R9 model casc_ack");
    chk(8'(reroute_req), 8'(casc_en && req[2]), "R10 model reroute_req");
    if (m_vv) chk(vec_data, m_vec, "R4 model vec_data");
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 3000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic settle(); #1; endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk(8'(intr), 0, "R1 intr after reset");
    chk(8'(vec_valid), 0, "R1 vec_valid after reset");
    chk(8'(casc_ack), 0, "R1 casc_ack after reset");

    // basic latch, acknowledge, held level
    req = 8'h20; cyc();
    chk(8'(intr), 1, "R2 edge latched");
    inta = 1; cyc(); inta = 0;
    chk(8'(vec_valid), 1, "R5 vector valid");
    chk(vec_data, 8'h55, "R4 vector line 5");
    chk(8'(intr), 0, "R5 intr low while vector held");
    cyc();
    chk(8'(vec_valid), 0, "R6 vector taken");
    chk(8'(intr), 0, "R2 held level no relatch");
    eoi = 1; cyc(); eoi = 0; req = 0; cyc();

    // masking and back-pressure
    mask = 8'h08; req = 8'h08; cyc();
    chk(8'(intr), 0, "R3 masked");
    cyc(); mask = 0; req = 0; cyc();
    chk(8'(intr), 1, "R3 latched after unmask");
    vec_ready = 0; inta = 1; cyc();
    chk(vec_data, 8'h53, "R4 vector line 3");
    req = 8'h01; cyc(); cyc();
    chk(8'(vec_valid), 1, "R6 valid held");
    chk(vec_data, 8'h53, "R6 data held, inta ignored");
    inta = 0; vec_ready = 1; cyc();
    chk(8'(vec_valid), 0, "R6 taken after ready");
    chk(8'(intr), 1, "R7 line 0 outranks line 3");
    inta = 1; cyc(); inta = 0; cyc();
    eoi = 1; cyc(); eoi = 0; req = 0; cyc();

    // nesting: line 3 in service
    req = 8'h40; cyc();
    chk(8'(intr), 0, "R7 lower held");
    req = 8'h42; cyc();
    chk(8'(intr), 1, "R7 preempt");
    inta = 1; cyc(); inta = 0;
    chk(vec_data, 8'h51, "R7 preempt vector");
    cyc();
    eoi = 1; cyc(); eoi = 0;
    chk(8'(intr), 0, "R8 line 3 still blocks 6");
    eoi = 1; cyc(); eoi = 0;
    chk(8'(intr), 1, "R8 line 6 released");
    inta = 1; cyc(); inta = 0;
    chk(vec_data, 8'h56, "R4 vector line 6");
    cyc(); eoi = 1; cyc(); eoi = 0; req = 0; cyc();

    // equal priority and same-cycle edge on acknowledged line
    req = 8'h10; cyc(); inta = 1; cyc(); inta = 0;
    chk(vec_data, 8'h54, "R4 vector line 4");
    req = 0; cyc(); req = 8'h10; cyc();
    chk(8'(intr), 0, "R7 equal held");
    eoi = 1; cyc(); eoi = 0;
    chk(8'(intr), 1, "R8 equal released");
    req = 0; cyc();
    req = 8'h10; inta = 1; cyc(); inta = 0;
    chk(vec_data, 8'h54, "R11 ack line 4");
    cyc();
    chk(8'(intr), 0, "R11 relatched waits");
    eoi = 1; cyc(); eoi = 0;
    chk(8'(intr), 1, "R11 edge in ack cycle kept");
    inta = 1; cyc(); inta = 0; cyc();
    req = 8'h01; cyc();
    inta = 1; eoi = 1; cyc(); inta = 0; eoi = 0;
    chk(vec_data, 8'h50, "R11 ack with eoi");
    cyc(); eoi = 1; cyc(); eoi = 0;
    req = 8'h41; cyc();
    chk(8'(intr), 1, "R11 eoi in ack cycle took effect");
    inta = 1; cyc(); inta = 0; cyc(); eoi = 1; cyc(); eoi = 0; req = 0; cyc();

    // linked mode
    casc_en = 1; casc_vec = 8'hC9; req = 8'h04; settle();
    chk(8'(reroute_req), 1, "R10 reroute follows req2");
    cyc();
    chk(8'(intr), 0, "R10 req2 ignored when linked");
    casc_irq = 1; cyc();
    chk(8'(intr), 1, "R9 secondary raises line 2");
    inta = 1; settle();
    chk(8'(casc_ack), 1, "R9 casc_ack");
    cyc(); inta = 0;
    chk(vec_data, 8'hC9, "R9 secondary vector");
    chk(8'(casc_ack), 0, "R9 casc_ack one cycle");
    casc_irq = 0; cyc(); eoi = 1; cyc(); eoi = 0;
    casc_en = 0; settle();
    chk(8'(reroute_req), 0, "R10 no reroute unlinked");
    req = 0; cyc(); cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule